// File: doc/BRIEF.md
# Synchronous Character Transmitter with Idle Fill

This block is the transmit half of a character-oriented synchronous serial controller. A processor writes characters into a one-entry holding register. At each bit-clock enable the block moves a character into a shift register and sends it out least significant bit first, with a programmable character length. Characters follow one another on the line with no gap between them.

When the holding register is empty at a character boundary and transmission is enabled, the block sends a fill character so the line stays synchronised. The fill comes either from a fixed sync register or from the last character the processor wrote. A start-of-message control keeps this fill running on purpose. Without it, a missing character is recorded as an underrun, and the underrun flag stays set until the processor clears it. When transmission is disabled, the block can also send a run of sixteen zero bits, the space sequence.

Top module: `sync_char_tx`

## Requirements
- R1: While reset is held and just after it is released, `txd` is 1, `buf_empty` is 1, `underrun` is 0 and `ch_load` is 0.
- R2: The character length is `len_sel` bits when `len_sel` is 1 to 7, and 8 bits when `len_sel` is 0. The length is captured when the character is loaded. Only the low-order (right-justified) bits of the character are sent, bit 0 first.
- R3: Each bit is held on `txd` for exactly one bit period. A bit period runs from one `bit_en` edge to the next. The first bit appears after the `bit_en` edge that loads the character, and the next character follows the last bit with no idle bit between them.
- R4: `buf_empty` goes to 0 in the cycle after a `wr_data` strobe. It returns to 1 in the cycle after the held character moves into the shift register.
- R5: `ch_load` pulses for one cycle after each `bit_en` edge that starts a character. This covers data characters, fill characters and the space sequence.
- R6: At a character boundary with `tx_en`=1, the holding register empty and `idle_sel`=0, the block sends the low-order bits of `sync_reg` as a fill character.
- R7: Under the same conditions with `idle_sel`=1, the block repeats the last character written through `wr_char` until new data is written.
- R8: A fill character that starts while `som_in`=0 sets `underrun`. A fill that starts while `som_in`=1 does not set it, and no fill is sent while `tx_en`=0.
- R9: `underrun` stays set until a cycle with `ur_clr`=1 and no new underrun event. In that cycle it clears.
- R10: Suppose `tx_en`=0, the shifter is idle, and `som_in` and `eom_in` are both 1 at a `bit_en` edge. The block then sends 16 consecutive zero bits.
- R11: When `tx_en`=0 and no character is in progress, `txd` stays at 1 (mark). A character that is waiting in the holding register is not started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-clock enable, one pulse per bit period |
| tx_en | input | 1 | Transmit enable |
| len_sel | input | 3 | Character length select, 0 means 8 |
| wr_data | input | 1 | Write strobe for the holding register |
| wr_char | input | 8 | Character to be written |
| som_in | input | 1 | Start-of-message: keep fill running, suppress underrun |
| eom_in | input | 1 | End-of-message, used with `som_in` for the space sequence |
| idle_sel | input | 1 | Fill source: 0 for `sync_reg`, 1 for the last written character |
| sync_reg | input | 8 | Fixed sync character |
| ur_clr | input | 1 | Write-one-to-clear for `underrun` |
| txd | output | 1 | Serial data out |
| buf_empty | output | 1 | Holding register empty |
| underrun | output | 1 | Sticky underrun flag |
| ch_load | output | 1 | One-cycle pulse when a character starts |

## Verification
The serial stream is driven through one sequence of phases. In the first, a character is written while transmission is disabled. This separates a design that holds queued data from one that starts it. Data then runs back to back at lengths 8, 5, 3 and 7. This exposes errors in the length decode, the masking and the bit order, and any gap between characters. Fill characters are then forced with each setting of `idle_sel`, and with `som_in` both high and low. This tells a fixed-sync fill from a repeat-last fill, and a suppressed underrun from a flagged one. The disabled-line phase and the space sequence close the run, and show whether the line stays at mark or emits exactly sixteen zero bits.

// File: rtl/sync_char_tx.sv
module sync_char_tx #(
  parameter int LEN_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_en,
  input  logic                  tx_en,
  input  logic [LEN_W-1:0]      len_sel,
  input  logic                  wr_data,
  input  logic [(1<<LEN_W)-1:0] wr_char,
  input  logic                  som_in,
  input  logic                  eom_in,
  input  logic                  idle_sel,
  input  logic [(1<<LEN_W)-1:0] sync_reg,
  input  logic                  ur_clr,
  output logic                  txd,
  output logic                  buf_empty,
  output logic                  underrun,
  output logic                  ch_load
);
  localparam int CHAR_W     = 1 << LEN_W;
  localparam int SPACE_BITS = 2 * CHAR_W;
  localparam int CNT_W      = $clog2(SPACE_BITS + 1);

  logic [CHAR_W-1:0] sh, hold, last;
  logic [CNT_W-1:0]  cnt;
  logic              busy, full;

  wire [CNT_W-1:0]  clen   = (len_sel == '0) ? CNT_W'(CHAR_W) : CNT_W'(len_sel);
  wire [CHAR_W-1:0] lmask  = (CHAR_W'(1) << clen) - CHAR_W'(1);
  wire              bound  = bit_en && (!busy || cnt == CNT_W'(1));
  wire              take   = bound && tx_en && full;
  wire              fill   = bound && tx_en && !full;
  wire              space  = bit_en && !busy && !tx_en && som_in && eom_in;
  wire [CHAR_W-1:0] fill_c = idle_sel ? last : sync_reg;

  assign txd       = busy ? sh[0] : 1'b1;
  assign buf_empty = !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh       <= '0;
      hold     <= '0;
      last     <= '0;
      cnt      <= '0;
      busy     <= 1'b0;
      full     <= 1'b0;
      underrun <= 1'b0;
      ch_load  <= 1'b0;
    end else begin
      ch_load <= take || fill || space;

      if (take) begin
        sh   <= hold & lmask;
        cnt  <= clen;
        busy <= 1'b1;
      end else if (fill) begin
        sh   <= fill_c & lmask;
        cnt  <= clen;
        busy <= 1'b1;
      end else if (space) begin
        sh   <= '0;
        cnt  <= CNT_W'(SPACE_BITS);
        busy <= 1'b1;
      end else if (bit_en && busy) begin
        sh  <= sh >> 1;
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) busy <= 1'b0;
      end

      if (wr_data) begin
        hold <= wr_char;
        last <= wr_char;
        full <= 1'b1;
      end else if (take) begin
        full <= 1'b0;
      end

      if (fill && !som_in) underrun <= 1'b1;
      else if (ur_clr)     underrun <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_char_tx_chk.sv
module sync_char_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic tx_en,
  input logic wr_data,
  input logic som_in,
  input logic ur_clr,
  input logic txd,
  input logic buf_empty,
  input logic underrun,
  input logic ch_load
);
  // R3: the line only moves after a bit-clock edge
  a_r3_txd_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_en) |-> $stable(txd));

  // R4: a write fills the holding register
  a_r4_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> !buf_empty);

  // R5: a character start follows a bit-clock edge
  a_r5_load_on_bit_en: assert property (@(posedge clk) disable iff (!rst_n)
    ch_load |-> $past(bit_en));

  // R8: underrun is raised only by an enabled edge without start-of-message
  a_r8_set_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> ($past(bit_en) && $past(tx_en) && !$past(som_in)));

  // R9: underrun holds until cleared
  a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !ur_clr) |=> underrun);
endmodule

bind sync_char_tx sync_char_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_en(tx_en),
  .wr_data(wr_data), .som_in(som_in), .ur_clr(ur_clr), .txd(txd),
  .buf_empty(buf_empty), .underrun(underrun), .ch_load(ch_load)
);

// File: tb/sim_sync_char_tx.sv
module sim_sync_char_tx;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, bit_en, tx_en, wr_data, som_in, eom_in, idle_sel, ur_clr;
  logic [2:0] len_sel;
  logic [7:0] wr_char, sync_reg;
  logic       txd, buf_empty, underrun, ch_load;

  sync_char_tx u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_en(tx_en), .len_sel(len_sel),
    .wr_data(wr_data), .wr_char(wr_char), .som_in(som_in), .eom_in(eom_in),
    .idle_sel(idle_sel), .sync_reg(sync_reg), .ur_clr(ur_clr),
    .txd(txd), .buf_empty(buf_empty), .underrun(underrun), .ch_load(ch_load)
  );

  int total = 0, bad = 0, nload = 0;
  bit done = 0;
  logic [15:0] q_d[$];
  int          q_l[$];
  string       q_t[$];

  task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic push(logic [15:0] d, int len, string tag);
    q_d.push_back(d & 16'((32'(1) << len) - 1));
    q_l.push_back(len);
    q_t.push_back(tag);
  endtask

  task automatic wait_load();
    do @(negedge clk); while (!ch_load);
  endtask

  task automatic write(logic [7:0] d);
    @(posedge clk); #1;
    wr_data = 1'b1; wr_char = d;
    @(posedge clk); #1;
    wr_data = 1'b0;
  endtask

  initial begin
    bit_en = 1'b0;
    forever begin
      repeat (3) @(posedge clk);
      #1 bit_en = 1'b1;
      @(posedge clk);
      #1 bit_en = 1'b0;
    end
  end

  initial begin
    logic [15:0] ed, got;
    int el;
    string tg;
    forever begin
      @(negedge clk);
      if (rst_n && ch_load) begin
        nload++;
        if (q_d.size() == 0) chk(0, "R5 R11 unexpected character start", 16'h1, 16'h0);
        else begin
          ed = q_d.pop_front(); el = q_l.pop_front(); tg = q_t.pop_front();
          got = '0;
          for (int i = 0; i < el; i++) begin
            do @(negedge clk); while (!bit_en);
            got[i] = txd;
          end
          chk(got == ed, {tg, " R3 serial bits"}, got, ed);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R3 watchdog act=%h exp=%h", 16'hdead, 16'h0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n0;
    rst_n = 0; tx_en = 0; wr_data = 0; som_in = 0; eom_in = 0; idle_sel = 0;
    ur_clr = 0; len_sel = 3'd0; wr_char = 8'h00; sync_reg = 8'h96;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(txd == 1'b1, "R1 txd", 16'(txd), 16'h1);
    chk(buf_empty == 1'b1, "R1 buf_empty", 16'(buf_empty), 16'h1);
    chk(underrun == 1'b0, "R1 underrun", 16'(underrun), 16'h0);
    chk(ch_load == 1'b0, "R1 ch_load", 16'(ch_load), 16'h0);

    // R11: queued data is held while disabled
    push(16'hA5, 8, "R2 len8");
    write(8'hA5);
    repeat (30) @(negedge clk);
    chk(txd == 1'b1, "R11 mark while disabled", 16'(txd), 16'h1);
    chk(buf_empty == 1'b0, "R4 held character", 16'(buf_empty), 16'h0);
    chk(nload == 0, "R11 no start while disabled", 16'(nload), 16'h0);

    #1 som_in = 1; tx_en = 1;
    wait_load();
    chk(buf_empty == 1'b1, "R4 empty after take", 16'(buf_empty), 16'h1);

    push(16'h96, 8, "R6 sync fill");
    wait_load();
    chk(underrun == 1'b0, "R8 som suppresses underrun", 16'(underrun), 16'h0);

    push(16'h3C, 8, "R2 len8 second");
    write(8'h3C);
    wait_load();

    #1 len_sel = 3'd5;
    push(16'hEB, 5, "R2 len5");
    write(8'hEB);
    wait_load();

    #1 idle_sel = 1;
    push(16'hEB, 5, "R7 repeat last");
    wait_load();

    #1 som_in = 0;
    push(16'hEB, 5, "R8 fill without som");
    wait_load();
    chk(underrun == 1'b1, "R8 underrun set", 16'(underrun), 16'h1);

    #1 len_sel = 3'd3; som_in = 1;
    push(16'h55, 3, "R2 len3");
    write(8'h55);
    wait_load();
    #1 tx_en = 0;
    chk(underrun == 1'b1, "R9 underrun sticky", 16'(underrun), 16'h1);
    @(posedge clk); #1 ur_clr = 1;
    @(posedge clk); #1 ur_clr = 0;
    @(negedge clk);
    chk(underrun == 1'b0, "R9 cleared by write one", 16'(underrun), 16'h0);

    #1 len_sel = 3'd7;
    push(16'hC3, 7, "R2 len7");
    write(8'hC3);
    #1 tx_en = 1;
    wait_load();
    #1 tx_en = 0;
    n0 = nload;
    repeat (60) @(negedge clk);
    chk(txd == 1'b1, "R11 mark after last character", 16'(txd), 16'h1);
    chk(nload == n0, "R11 no fill while disabled", 16'(nload), 16'(n0));
    chk(underrun == 1'b0, "R8 no underrun while disabled", 16'(underrun), 16'h0);

    #1 eom_in = 1;
    push(16'h0000, 16, "R10 space sequence");
    wait_load();
    #1 eom_in = 0;
    repeat (90) @(negedge clk);
    chk(txd == 1'b1, "R11 mark after space", 16'(txd), 16'h1);
    chk(q_d.size() == 0, "R5 all characters started", 16'(q_d.size()), 16'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule